// File: doc/BRIEF.md
# I2C Byte Master with Host Register File

This block is an I2C bus master that a host processor drives one byte at a time through five byte-wide register addresses. The host loads a 16-bit divider, turns the core on, places a byte in the transmit holding register and writes a command. A single command byte can put a start condition in front of a byte transfer and a stop condition after it. The block then shifts the byte out MSB first on open-drain SCL and SDA, or shifts a byte in. It takes or gives the ninth acknowledge bit and flags completion in its status register. That flag can also drive an interrupt line.

Each bit on the wire takes five phases, and each phase lasts `divider + 1` clock cycles. The SCL period is therefore five times the divided tick. A slave that holds SCL low while the master has released it freezes the phase count until SCL rises. While the master sends a 1 it watches SDA. If SDA reads low, the master has lost arbitration: it releases both lines and reports the loss. Start and stop conditions are tracked on the wire no matter which master makes them, so software can see whether the bus is occupied.

Register map (address: contents):
- 0: divider bits 7:0.
- 1: divider bits 15:8.
- 2: control. Bit 7 turns the core on and bit 6 enables the interrupt.
- 3: writes load the transmit byte, reads return the last received byte.
- 4: writes issue a command, reads return status.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, addresses 0 and 1 read 0xFF, control, status and received data read 0x00, irq is low, and neither SCL nor SDA is pulled low.
- R2: Addresses 0, 1 and 2 read back what was written. Control bit 7 is core-on and bit 6 is interrupt-enable. A write to address 3 is not visible at address 3, whose reads return the received byte.
- R3: Command bit 7 (start) with bit 4 (write) makes a start condition and then sends the transmit byte MSB first. The master releases SDA for the ninth bit and stores the level it reads there in status bit 7, where 1 means the slave did not acknowledge.
- R4: Command bit 5 (read) takes in eight bits MSB first and stores them at address 3. In the ninth bit the master pulls SDA low, or releases SDA when command bit 3 is also set (0x28 compared with 0x20).
- R5: Command bit 6 (stop) makes a stop condition after the byte and acknowledge of the same command. Written alone (0x40), it makes only a stop condition.
- R6: Status bit 1 (transfer in progress) is high from the clock edge that accepts a command until that command's last bit is complete. When it falls, status bit 0 (interrupt flag) sets.
- R7: irq is high exactly when the interrupt flag and control bit 6 are both set. A command write with bit 0 set clears the flag.
- R8: With no clock stretching, the SCL period is 5 x (divider + 1) clock cycles.
- R9: While a slave holds SCL low after the master has released it, the bit does not advance, and the transfer finishes correctly once SCL is freed.
- R10: If SDA reads low during a data bit in which the master sends 1, the master releases both lines and ends the command. It then sets status bit 5 (arbitration lost) and the interrupt flag, and clears status bit 1.
- R11: Status bit 6 (bus busy) sets when SDA falls while SCL is high and clears when SDA rises while SCL is high, for conditions from any master.
- R12: A command write while control bit 7 is clear is ignored: no transfer starts and both lines stay released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register address, 0 to 4 |
| reg_we | input | 1 | Write strobe for one cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| irq | output | 1 | Interrupt request |
| scl_in | input | 1 | Level on the SCL wire |
| scl_pull | output | 1 | 1 pulls SCL low |
| sda_in | input | 1 | Level on the SDA wire |
| sda_pull | output | 1 | 1 pulls SDA low |

## Verification
The bench builds the block with its default parameters: a 16-bit divider that resets to all ones. It then programs the divider at run time to 3 and later to 1. These short divider values let the bench run many whole byte transfers, including stretched and aborted ones, within the cycle budget. They also make the exact 20- and 10-cycle SCL periods easy to measure. A wired-AND bus model plays the slave, a second master that makes arbitration collide, and a slave that stretches SCL, which brings the acknowledge, NACK, arbitration and busy paths within reach.

// File: rtl/i2c_byte_master.sv
`timescale 1ns/1ps
module i2c_byte_master #(
  parameter int              PRE_W   = 16,
  parameter logic [PRE_W-1:0] PRE_RST = '1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_addr,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  input  logic       scl_in,
  output logic       scl_pull,
  input  logic       sda_in,
  output logic       sda_pull
);

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0, ST_START = 3'd1, ST_DATA = 3'd2, ST_ACK = 3'd3, ST_STOP = 3'd4
  } st_t;

  st_t              st;
  logic [PRE_W-1:0] pre, cnt;
  logic             core_en, irq_en;
  logic [7:0]       txd, rxd, sh;
  logic             tip, ifl, al, rxack, busy;
  logic             c_dat, c_rd, c_sto, c_nack;
  logic [2:0]       ph, bitn;
  logic             scl_r, sda_r, scl_s, sda_s, sda_p;
  logic             scl_o, sda_o, bit_d;

  wire wr_cmd  = reg_we && reg_addr == 3'd4;
  wire accept  = wr_cmd && core_en && !tip && |reg_wdata[7:4];
  wire tick    = cnt == '0;
  wire stretch = (ph == 3'd2 || ph == 3'd3) && scl_o && !scl_s;
  wire step    = st != ST_IDLE && tick && !stretch;
  wire samp    = step && ph == 3'd3;
  wire last    = step && ph == 3'd4;
  wire lost    = samp && st == ST_DATA && !c_rd && sh[7] && !sda_s;
  wire fin     = last && (st == ST_STOP || (st == ST_ACK && !c_sto) ||
                          (st == ST_START && !c_dat && !c_sto));

  always_comb begin
    bit_d = 1'b1;
    if (st == ST_DATA) bit_d = c_rd ? 1'b1 : sh[7];
    if (st == ST_ACK)  bit_d = c_rd ? c_nack : 1'b1;
  end

  always_comb begin
    scl_o = scl_r;
    sda_o = sda_r;
    unique case (st)
      ST_START: begin
        scl_o = (ph == 3'd0) ? scl_r : (ph <= 3'd3);
        sda_o = ph < 3'd2;
      end
      ST_STOP: begin
        scl_o = ph >= 3'd1;
        sda_o = ph >= 3'd3;
      end
      ST_DATA, ST_ACK: begin
        scl_o = ph >= 3'd1 && ph <= 3'd3;
        sda_o = bit_d;
      end
      default: ;
    endcase
  end

  assign scl_pull = !scl_o;
  assign sda_pull = !sda_o;
  assign irq      = ifl && irq_en;

  always_comb begin
    unique case (reg_addr)
      3'd0:    reg_rdata = pre[7:0];
      3'd1:    reg_rdata = 8'(pre >> 8);
      3'd2:    reg_rdata = {core_en, irq_en, 6'b0};
      3'd3:    reg_rdata = rxd;
      3'd4:    reg_rdata = {rxack, busy, al, 3'b0, tip, ifl};
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;  pre <= PRE_RST;  cnt <= '0;
      core_en <= 1'b0; irq_en <= 1'b0;
      txd <= '0; rxd <= '0; sh <= '0;
      tip <= 1'b0; ifl <= 1'b0; al <= 1'b0; rxack <= 1'b0; busy <= 1'b0;
      c_dat <= 1'b0; c_rd <= 1'b0; c_sto <= 1'b0; c_nack <= 1'b0;
      ph <= '0; bitn <= '0;
      scl_r <= 1'b1; sda_r <= 1'b1; scl_s <= 1'b1; sda_s <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_s <= scl_in;
      sda_s <= sda_in;
      sda_p <= sda_s;
      scl_r <= scl_o;
      sda_r <= sda_o;

      if (scl_s && sda_p && !sda_s)      busy <= 1'b1;
      else if (scl_s && !sda_p && sda_s) busy <= 1'b0;

      if (reg_we) begin
        case (reg_addr)
          3'd0: pre[7:0] <= reg_wdata;
          3'd1: pre[PRE_W-1:8] <= reg_wdata[PRE_W-9:0];
          3'd2: begin core_en <= reg_wdata[7]; irq_en <= reg_wdata[6]; end
          3'd3: txd <= reg_wdata;
          default: ;
        endcase
      end
      if (wr_cmd && reg_wdata[0]) ifl <= 1'b0;

      if (accept) begin
        tip    <= 1'b1;
        al     <= 1'b0;
        c_dat  <= |reg_wdata[5:4];
        c_rd   <= reg_wdata[5] && !reg_wdata[4];
        c_sto  <= reg_wdata[6];
        c_nack <= reg_wdata[3];
        sh     <= txd;
        ph     <= '0;
        bitn   <= 3'd7;
        cnt    <= pre;
        st     <= reg_wdata[7] ? ST_START : (|reg_wdata[5:4] ? ST_DATA : ST_STOP);
      end else if (st != ST_IDLE) begin
        if (!stretch) cnt <= tick ? pre : cnt - 1'b1;
        if (step) ph <= (ph == 3'd4) ? 3'd0 : ph + 3'd1;
        if (samp && st == ST_DATA && c_rd) sh <= {sh[6:0], sda_s};
        if (samp && st == ST_ACK && !c_rd) rxack <= sda_s;
        if (lost) begin
          al <= 1'b1; ifl <= 1'b1; tip <= 1'b0; st <= ST_IDLE;
          scl_r <= 1'b1; sda_r <= 1'b1;
        end else if (fin) begin
          st <= ST_IDLE; tip <= 1'b0; ifl <= 1'b1;
          if (c_rd) rxd <= sh;
        end else if (last) begin
          case (st)
            ST_START: st <= c_dat ? ST_DATA : ST_STOP;
            ST_DATA: begin
              if (!c_rd) sh <= {sh[6:0], 1'b0};
              if (bitn == 3'd0) st <= ST_ACK;
              else bitn <= bitn - 3'd1;
            end
            ST_ACK: st <= ST_STOP;
            default: ;
          endcase
        end
      end

      if (!core_en) begin
        st <= ST_IDLE; tip <= 1'b0; scl_r <= 1'b1; sda_r <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/i2c_byte_master_chk.sv
`timescale 1ns/1ps
module i2c_byte_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic [2:0] reg_addr,
  input logic       tip,
  input logic       ifl,
  input logic       al,
  input logic       core_en,
  input logic       scl_pull,
  input logic       sda_pull,
  input logic [2:0] st
);
  wire cond_state = st == 3'd1 || st == 3'd4;

  // R6
  tip_done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tip) && core_en && $past(core_en) |-> ifl);

  // R6
  tip_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tip) |-> $past(reg_we && reg_addr == 3'd4));

  // R3
  sda_steady_high_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_en && !scl_pull && $past(!scl_pull) && !$stable(sda_pull) |-> cond_state);

  // R10
  lost_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(al) |-> !scl_pull && !sda_pull);

  // R12
  off_no_tip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !core_en && $past(!core_en) |-> !tip);
endmodule

bind i2c_byte_master i2c_byte_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .tip(tip), .ifl(ifl), .al(al), .core_en(core_en),
  .scl_pull(scl_pull), .sda_pull(sda_pull), .st(st)
);

// File: tb/i2c_byte_master_tb.sv
`timescale 1ns/1ps
module i2c_byte_master_tb;
  localparam int STRETCH = 60;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [2:0] reg_addr = '0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq, scl_pull, sda_pull;
  logic       scl_ext_low = 1'b0, sda_slv_low = 1'b0, sda_ext_low = 1'b0;
  logic       scl_w, sda_w;
  assign scl_w = ~(scl_pull | scl_ext_low);
  assign sda_w = ~(sda_pull | sda_slv_low | sda_ext_low);

  i2c_byte_master u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_in(scl_w), .scl_pull(scl_pull), .sda_in(sda_w), .sda_pull(sda_pull)
  );

  int n_chk = 0, n_fail = 0;
  typedef struct packed { logic [7:0] b; logic a; } item_t;
  item_t exp_q[$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // bus model: monitor and slave
  int bit_idx = 0, n_start = 0, n_stop = 0, stretch_at = -1, arb_at = -1;
  bit in_frame = 0, slv_tx = 0, slv_nack = 0;
  logic [7:0] mon_sh = '0, slv_byte = '0;
  realtime last_rise = 0, scl_per = 0;

  task automatic drive_slave();
    if (bit_idx == 8) sda_slv_low = !slv_tx && !slv_nack;
    else              sda_slv_low = slv_tx && !slv_byte[7-bit_idx];
  endtask

  task automatic slave_tx(input logic [7:0] b);
    slv_byte = b; slv_tx = 1;
    if (in_frame && !scl_w) drive_slave();
  endtask

  task automatic slave_rx(input bit nack);
    slv_tx = 0; slv_nack = nack;
    if (in_frame && !scl_w) drive_slave();
  endtask

  task automatic score(input logic [7:0] b, input logic a);
    item_t e;
    n_chk++;
    if (exp_q.size() == 0) begin
      n_fail++;
      $display("FAIL R3/R4 unexpected byte: actual %0h/%0b expected none", b, a);
    end else begin
      e = exp_q.pop_front();
      if (e.b !== b || e.a !== a) begin
        n_fail++;
        $display("FAIL R3/R4 bus byte: actual %0h/%0b expected %0h/%0b", b, a, e.b, e.a);
      end
    end
  endtask

  always @(negedge sda_w) if (scl_w === 1'b1) begin in_frame = 1; bit_idx = 0; n_start++; end
  always @(posedge sda_w) if (scl_w === 1'b1) begin in_frame = 0; n_stop++; end

  always @(posedge scl_w) begin
    scl_per = $realtime - last_rise;
    last_rise = $realtime;
    if (in_frame) begin
      if (bit_idx < 8) begin mon_sh = {mon_sh[6:0], sda_w}; bit_idx++; end
      else begin
        bit_idx = 0;
        score(mon_sh, sda_w);
        if (slv_tx && sda_w) slv_tx = 0;
      end
    end
  end

  always @(negedge scl_w) if (in_frame) begin
    if (arb_at == bit_idx) begin sda_ext_low = 1; arb_at = -1; end
    drive_slave();
    if (stretch_at == bit_idx) begin
      stretch_at = -1;
      scl_ext_low = 1;
      #(STRETCH * 8);
      scl_ext_low = 0;
    end
  end

  // driver tasks
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_idle(output int cyc);
    logic [7:0] s;
    cyc = 0;
    do begin rd(3'd4, s); cyc++; end while (s[1] && cyc < 20000);
    if (cyc >= 20000) check("R6 transfer never ends", 1, 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v;
    int c, base;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    n_start = 0; n_stop = 0;

    // R1 reset values
    rd(3'd0, v); check("R1 prescale low", v, 8'hFF);
    rd(3'd1, v); check("R1 prescale high", v, 8'hFF);
    rd(3'd2, v); check("R1 control", v, 8'h00);
    rd(3'd4, v); check("R1 status", v, 8'h00);
    rd(3'd3, v); check("R1 rx data", v, 8'h00);
    check("R1 irq", irq, 0);
    check("R1 lines released", {scl_pull, sda_pull}, 2'b00);

    // R12 command ignored while off
    wr(3'd4, 8'h90);
    repeat (30) @(negedge clk);
    rd(3'd4, v); check("R12 status stays idle", v, 8'h00);
    check("R12 no start on bus", n_start, 0);
    check("R12 lines released", {scl_w, sda_w}, 2'b11);

    // R2 register map
    wr(3'd0, 8'h03); wr(3'd1, 8'h00); wr(3'd2, 8'hC0);
    rd(3'd0, v); check("R2 prescale low", v, 8'h03);
    rd(3'd1, v); check("R2 prescale high", v, 8'h00);
    rd(3'd2, v); check("R2 control", v, 8'hC0);
    wr(3'd3, 8'hA6);
    rd(3'd3, v); check("R2 tx not visible", v, 8'h00);

    // R3 start+write with ack, R6 tip, R7 irq
    slave_rx(0);
    exp_q.push_back({8'hA6, 1'b0});
    wr(3'd4, 8'h90);
    rd(3'd4, v); check("R6 tip high after accept", v[1:0], 2'b10);
    wait_idle(c);
    rd(3'd4, v); check("R3 R6 R11 status after ack", v, 8'h41);
    check("R7 irq on flag", irq, 1);
    wr(3'd4, 8'h01);
    rd(3'd4, v); check("R7 ack clears flag", v[0], 0);
    check("R7 irq low", irq, 0);

    // R3 write with NACK
    slave_rx(1);
    exp_q.push_back({8'h3C, 1'b1});
    wr(3'd3, 8'h3C); wr(3'd4, 8'h10);
    wait_idle(c);
    rd(3'd4, v); check("R3 nack status", v, 8'hC1);
    wr(3'd4, 8'h01);

    // R8 period with divider 3
    slave_rx(0);
    exp_q.push_back({8'h55, 1'b0});
    wr(3'd3, 8'h55); wr(3'd4, 8'h10);
    wait_idle(c);
    check("R8 scl period div3", int'(scl_per), 160);
    wr(3'd4, 8'h01);

    // R4 read with ack
    slave_tx(8'hC9);
    exp_q.push_back({8'hC9, 1'b0});
    wr(3'd4, 8'h20);
    wait_idle(c);
    rd(3'd3, v); check("R4 read byte", v, 8'hC9);
    wr(3'd4, 8'h01);

    // R4 read with nack and R5 folded stop
    slave_tx(8'h5A);
    exp_q.push_back({8'h5A, 1'b1});
    wr(3'd4, 8'h68);
    wait_idle(c);
    repeat (4) @(negedge clk);
    rd(3'd3, v); check("R4 read nack byte", v, 8'h5A);
    check("R5 folded stop seen", n_stop, 1);
    rd(3'd4, v); check("R11 busy clears on stop", v[6], 0);
    check("R5 lines idle", {scl_w, sda_w}, 2'b11);
    wr(3'd4, 8'h01);

    // R8 with divider 1
    wr(3'd2, 8'h00); wr(3'd0, 8'h01); wr(3'd2, 8'hC0);
    slave_rx(0);
    exp_q.push_back({8'hA0, 1'b0});
    wr(3'd3, 8'hA0); wr(3'd4, 8'h90);
    wait_idle(base);
    check("R8 scl period div1", int'(scl_per), 80);
    wr(3'd4, 8'h01);

    // R5 stop only
    wr(3'd4, 8'h40);
    wait_idle(c);
    repeat (4) @(negedge clk);
    check("R5 stop only", n_stop, 2);
    rd(3'd4, v); check("R5 flag after stop", v[6] | v[1] | !v[0], 0);
    wr(3'd4, 8'h01);

    // R9 stretch
    slave_rx(0);
    stretch_at = 3;
    exp_q.push_back({8'hA0, 1'b0});
    wr(3'd4, 8'h90);
    wait_idle(c);
    check("R9 stretch delays", c > base + STRETCH / 2, 1);
    wr(3'd4, 8'h41);
    wait_idle(c);

    // R11 foreign start and stop
    repeat (4) @(negedge clk);
    sda_ext_low = 1;
    repeat (5) @(negedge clk);
    rd(3'd4, v); check("R11 busy on foreign start", v[6], 1);
    sda_ext_low = 0;
    repeat (5) @(negedge clk);
    rd(3'd4, v); check("R11 idle on foreign stop", v[6], 0);

    // R10 arbitration lost
    slave_rx(0);
    arb_at = 2;
    wr(3'd3, 8'hE0); wr(3'd4, 8'h90);
    wait_idle(c);
    rd(3'd4, v); check("R10 status", v & 8'h23, 8'h21);
    check("R10 lines released", {scl_pull, sda_pull}, 2'b00);
    check("R10 irq", irq, 1);
    sda_ext_low = 0;
    wr(3'd4, 8'h01);
    repeat (5) @(negedge clk);
    rd(3'd4, v); check("R10 R11 bus free", v[6], 0);

    // R7 irq masked
    wr(3'd2, 8'h80);
    slave_rx(0);
    exp_q.push_back({8'h42, 1'b0});
    wr(3'd3, 8'h42); wr(3'd4, 8'hD0);
    wait_idle(c);
    rd(3'd4, v); check("R7 flag set while masked", v[0], 1);
    check("R7 irq masked", irq, 0);
    wr(3'd2, 8'hC0);
    @(negedge clk); check("R7 irq unmasked", irq, 1);
    wr(3'd4, 8'h01);
    @(negedge clk); check("R7 irq cleared", irq, 0);

    repeat (10) @(negedge clk);
    check("R3 R4 all bytes seen", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule